// File: doc/BRIEF.md
# Period-Match Timer with Fine-Resolution PWM

This block is an 8-bit timer that advances on prescaled instruction cycles, where one instruction cycle is four input clocks. An 8-bit period register bounds the count. When the count equals the period register on an advance, the timer returns to zero instead of incrementing. Each such match feeds a postscaler, and the postscaler raises an interrupt flag once every N matches.

The same timer drives a pulse-width output with 10-bit duty resolution. The 8-bit count is joined with a 2-bit fine phase taken from the prescaler chain, which gives a 10-bit running position. The output rises at each period start. It falls when the running position reaches the duty value. The duty value is double-buffered, so software may rewrite it at any moment without producing a glitched period.

Software drives the block through a small write port with five addresses: control, period, duty high byte, duty low bits, and flag clear. The PWM period is (PERIOD+1) × 4 × P input clocks, where P is the prescale factor.

Top module: `ptmr_top`

## Requirements
- R1: After reset, countOut is 0, pwmOut is 0 and matchFlag is 0. The period register resets to 255. The control register, the duty value and the postscaler reset to 0.
- R2: The control register is at address 0. Its bits [1:0] choose the prescale P: 00 gives 1, 01 gives 4, 10 and 11 give 16. Bit 2 is the run enable. While bit 2 is 1, the count advances once every 4×P clocks. While bit 2 is 0, the count holds its value.
- R3: The period register is at address 1. If the count equals the period register when it advances, the next count is 0. One PWM period therefore lasts (PERIOD+1)×4×P clocks.
- R4: Control bits [6:3] hold k. matchFlag sets on every (k+1)-th period match. Any write to address 4 clears matchFlag. If a set and a clear fall in the same cycle, the set wins.
- R5: A write to the control register never clears or changes the count.
- R6: The duty value D is {address 2 byte, address 3 bits [1:0]}, so the address 3 bits are the low-order bits. pwmOut rises in the cycle the count returns to 0 at a match. It falls after D×P clocks.
- R7: If D is 0, pwmOut stays low for the whole period.
- R8: If D is 4×(PERIOD+1) or greater, pwmOut stays high for the whole period.
- R9: A newly written D takes effect only at the next period start. The period already running keeps the old D.
- R10: Control bit 7 gates pwmOut. While bit 7 is 0, pwmOut is 0, and the timer and postscaler keep running.
- R11: If the period register is written below the current count, the count runs on to 255 and wraps to 0. That wrap is not a match: it does not advance the postscaler and does not restart the PWM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; four clocks make one instruction cycle |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 control, 1 period, 2 duty high, 3 duty low, 4 flag clear) |
| wrData | input | 8 | Write data |
| pwmOut | output | 1 | Pulse-width output |
| matchFlag | output | 1 | Postscaled match interrupt flag |
| countOut | output | 8 | Current timer count |

## Verification
The bench targets the following corner cases. Each entry gives the case, then what a faulty design would do.
- **Duty boundary.** With D exactly 4×(PERIOD+1), the output must stay high, and with D one less it must drop for one clock. An off-by-one in the 10-bit compare would clip the first case or stretch the second.
- **Duty rewrite mid-period.** D is rewritten a few clocks into a period. A design without the duty buffer would cut the current pulse short or lengthen it.
- **Live control changes.** The prescale is changed while the timer is halted and again while it runs. A design that clears the count on a control write, or that misses the advance when the prescaler phase is already past the new limit, would diverge from the cycle-by-cycle model.
- **Period lowered below the count.** The period register is lowered below the current count. A design that treats the overflow wrap as a match would set the flag or restart the pulse early.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int TmrW      = 8;               // timer and period width
  localparam int FineW     = 2;               // fine phase bits joined to the count
  localparam int PostW     = 4;               // postscaler field width
  localparam int PselW     = 2;               // prescale select width
  localparam int PreMaxLog = 4;               // log2 of largest prescale (16)
  localparam int SubW      = FineW + PreMaxLog;
  localparam int DutyW     = TmrW + FineW;
  localparam int AddrW     = 3;
  localparam int RegW      = TmrW;

  localparam logic [AddrW-1:0] AddrCtrl   = 3'd0;
  localparam logic [AddrW-1:0] AddrPeriod = 3'd1;
  localparam logic [AddrW-1:0] AddrDutyHi = 3'd2;
  localparam logic [AddrW-1:0] AddrDutyLo = 3'd3;
  localparam logic [AddrW-1:0] AddrFlagCl = 3'd4;

  localparam int BitRun   = PselW;
  localparam int BitPostL = PselW + 1;
  localparam int BitPostH = PselW + PostW;
  localparam int BitPwmEn = PselW + PostW + 1;

  typedef struct packed {
    logic             tick;      // timer advances at this edge
    logic             on;        // run enable
    logic [FineW-1:0] fineNext;  // fine phase after this edge
  } strobe_t;

  typedef struct packed {
    logic [TmrW-1:0]  period;
    logic [DutyW-1:0] dutyBuf;
    logic             pwmEn;
  } cfg_t;
endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [RegW-1:0]  wrData,
  input  logic             matchIn,
  output strobe_t          strb,
  output cfg_t             cfg,
  output logic             flagOut
);
  logic [RegW-1:0]  ctrlQ;
  logic [TmrW-1:0]  periodQ;
  logic [TmrW-1:0]  dutyHiQ;
  logic [FineW-1:0] dutyLoQ;
  logic [SubW-1:0]  subQ, subNext, subLimit;
  logic [PostW-1:0] postQ, postSel;
  logic             flagQ, flagSet, flagClr, runOn, tick;
  logic [1:0]       stage;

  assign runOn   = ctrlQ[BitRun];
  assign postSel = ctrlQ[BitPostH:BitPostL];

  // prescale 4^stage instruction-cycle stretch; select 11 aliases to 16
  always_comb begin
    unique case (ctrlQ[PselW-1:0])
      2'b00:   stage = 2'd0;
      2'b01:   stage = 2'd1;
      default: stage = 2'd2;
    endcase
  end

  assign subLimit = SubW'((1 << (FineW + FineW * int'(stage))) - 1);
  assign tick     = runOn && (subQ >= subLimit);

  always_comb begin
    if (tick)       subNext = '0;
    else if (runOn) subNext = subQ + 1'b1;
    else            subNext = subQ;
  end

  assign strb.tick     = tick;
  assign strb.on       = runOn;
  assign strb.fineNext = FineW'(subNext >> (FineW * int'(stage)));

  assign cfg.period  = periodQ;
  assign cfg.dutyBuf = {dutyHiQ, dutyLoQ};
  assign cfg.pwmEn   = ctrlQ[BitPwmEn];

  assign flagSet = matchIn && (postQ >= postSel);
  assign flagClr = wrEn && (wrAddr == AddrFlagCl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      periodQ <= '1;
      dutyHiQ <= '0;
      dutyLoQ <= '0;
      subQ    <= '0;
      postQ   <= '0;
      flagQ   <= 1'b0;
    end else begin
      subQ <= subNext;
      if (matchIn) postQ <= flagSet ? '0 : postQ + 1'b1;
      if (flagSet)      flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
      if (wrEn) begin
        unique case (wrAddr)
          AddrCtrl:   ctrlQ   <= wrData;
          AddrPeriod: periodQ <= wrData;
          AddrDutyHi: dutyHiQ <= wrData;
          AddrDutyLo: dutyLoQ <= wrData[FineW-1:0];
          default:    ;
        endcase
      end
    end
  end

  assign flagOut = flagQ;

  // flag only ever rises right after a period match
  p_flag_after_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(matchIn));
endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  cfg_t            cfg,
  output logic            matchOut,
  output logic [TmrW-1:0] countOut,
  output logic            pwmRaw
);
  logic [TmrW-1:0]  countQ, countNext;
  logic [DutyW-1:0] activeQ, extNext;
  logic             atTop, pwmQ;

  assign atTop    = (countQ == cfg.period);
  assign matchOut = strb.tick && atTop;

  always_comb begin
    if (!strb.tick) countNext = countQ;
    else if (atTop) countNext = '0;
    else            countNext = countQ + 1'b1;
  end

  assign extNext = {countNext, strb.fineNext};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      activeQ <= '0;
      pwmQ    <= 1'b0;
    end else begin
      countQ <= countNext;
      if (matchOut) begin
        activeQ <= cfg.dutyBuf;
        pwmQ    <= |cfg.dutyBuf;
      end else if (strb.on && (extNext == activeQ)) begin
        pwmQ <= 1'b0;
      end
    end
  end

  assign countOut = countQ;
  assign pwmRaw   = pwmQ;

  p_match_wraps_r3: assert property (@(posedge clk) disable iff (!rstN)
    matchOut |=> (countQ == '0));
  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.on |=> $stable(countQ));
  p_zero_duty_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (matchOut && (cfg.dutyBuf == '0)) |=> !pwmQ);
  p_low_until_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmQ && !matchOut) |=> !pwmQ);
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [RegW-1:0]  wrData,
  output logic             pwmOut,
  output logic             matchFlag,
  output logic [TmrW-1:0]  countOut
);
  strobe_t strb;
  cfg_t    cfg;
  logic    match, pwmRaw;

  ptmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .matchIn(match), .strb(strb), .cfg(cfg), .flagOut(matchFlag)
  );

  ptmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg),
    .matchOut(match), .countOut(countOut), .pwmRaw(pwmRaw)
  );

  assign pwmOut = pwmRaw & cfg.pwmEn;

  p_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.pwmEn |-> !pwmOut);
endmodule

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut, matchFlag;
  logic [7:0] countOut;

  int total = 0;
  int bad = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  ptmr_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .matchFlag(matchFlag), .countOut(countOut)
  );

  always #10 clk = ~clk;   // 50 MHz

  // ---------------- behavioural reference model ----------------
  int subM, tmrM, postM, actM, dutyM, perM, ctrlM;
  bit flagM, pwmM;

  always @(posedge clk) begin
    int sel, presc, lim, nsub, ntmr, fine;
    bit on, tk, mt, setNow;
    if (!rstN) begin
      subM = 0; tmrM = 0; postM = 0; actM = 0; dutyM = 0;
      perM = 255; ctrlM = 0; flagM = 0; pwmM = 0;
    end else begin
      sel   = ctrlM % 4;
      presc = (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
      lim   = 4 * presc - 1;
      on    = ((ctrlM / 4) % 2) == 1;
      tk    = on && (subM >= lim);
      nsub  = tk ? 0 : (on ? subM + 1 : subM);
      mt    = tk && (tmrM == perM);
      ntmr  = tk ? (mt ? 0 : (tmrM + 1) % 256) : tmrM;
      fine  = (nsub / presc) % 4;
      if (mt) begin
        actM = dutyM;
        pwmM = (dutyM != 0);
      end else if (on && (ntmr * 4 + fine == actM)) begin
        pwmM = 0;
      end
      setNow = 0;
      if (mt) begin
        if (postM >= (ctrlM / 8) % 16) begin
          postM = 0; flagM = 1; setNow = 1;
        end else postM = postM + 1;
      end
      subM = nsub;
      tmrM = ntmr;
      if (wrEn) begin
        case (wrAddr)
          3'd0: ctrlM = wrData;
          3'd1: perM  = wrData;
          3'd2: dutyM = wrData * 4 + dutyM % 4;
          3'd3: dutyM = (dutyM / 4) * 4 + wrData % 4;
          3'd4: if (!setNow) flagM = 0;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && checking) begin
      total += 3;
      if (countOut != tmrM[7:0]) begin
        bad++; $display("FAIL R3 count act=%0d exp=%0d t=%0t", countOut, tmrM, $time);
      end
      if (matchFlag != flagM) begin
        bad++; $display("FAIL R4 flag act=%0b exp=%0b t=%0t", matchFlag, flagM, $time);
      end
      if (pwmOut != (pwmM && (ctrlM >= 128))) begin
        bad++; $display("FAIL R6 pwm act=%0b exp=%0b t=%0t", pwmOut, pwmM && (ctrlM >= 128), $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitRise();
    bit prev = pwmOut;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pwmOut && !prev) return;
      prev = pwmOut;
    end
  endtask

  task automatic highTime(output int n);
    waitRise();
    n = 0;
    while (pwmOut && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic periodTime(output int n);
    bit prev;
    waitRise();
    n = 0;
    prev = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (pwmOut && !prev) return;
      prev = pwmOut;
    end
  endtask

  task automatic countLevel(input bit lvl, input int span, output int n);
    n = 0;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (pwmOut == lvl) n++;
    end
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    int n, c;
    bit seen;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    checking = 1'b1;
    @(negedge clk);
    check(countOut == 0 && pwmOut == 0 && matchFlag == 0, "R1 reset state",
          {countOut, pwmOut, matchFlag}, 0);

    // period 9, D = 20, prescale 1, k = 2, output enabled
    wr(3'd1, 8'd9); wr(3'd2, 8'd5); wr(3'd3, 8'd0); wr(3'd0, 8'h94);
    highTime(n);   check(n == 20, "R6 high time P=1", n, 20);
    periodTime(n); check(n == 40, "R3 period P=1", n, 40);

    wr(3'd0, 8'h95);            // prescale 4
    waitRise();
    highTime(n);   check(n == 80, "R2 high time P=4", n, 80);
    periodTime(n); check(n == 160, "R2 period P=4", n, 160);

    // halt, then rewrite control while halted
    repeat (37) @(negedge clk);
    wr(3'd0, 8'h91);
    c = countOut;
    wr(3'd0, 8'h92);
    repeat (20) @(negedge clk);
    check(countOut == c, "R5 control write keeps count", countOut, c);
    wr(3'd0, 8'h96);            // run, prescale 16
    waitRise();
    highTime(n);   check(n == 320, "R2 high time P=16", n, 320);
    periodTime(n); check(n == 640, "R2 period P=16", n, 640);

    // back to prescale 1; double-buffer test
    wr(3'd0, 8'h94);
    wr(3'd2, 8'd2);             // D = 8
    waitRise(); waitRise();
    wr(3'd2, 8'd7);             // D = 28, mid-period
    repeat (10) @(negedge clk);
    check(pwmOut == 0, "R9 old duty kept this period", pwmOut, 0);
    highTime(n);   check(n == 28, "R9 new duty next period", n, 28);

    // zero duty
    wr(3'd2, 8'd0);
    repeat (100) @(negedge clk);
    countLevel(1'b1, 40, n); check(n == 0, "R7 zero duty stays low", n, 0);

    // duty exactly 4*(PERIOD+1): always high
    wr(3'd2, 8'd10);
    repeat (100) @(negedge clk);
    countLevel(1'b0, 40, n); check(n == 0, "R8 full duty stays high", n, 0);
    // duty one below: drops for one clock
    wr(3'd2, 8'd9); wr(3'd3, 8'd3);
    repeat (100) @(negedge clk);
    countLevel(1'b0, 40, n); check(n == 1, "R8 boundary minus one", n, 1);
    wr(3'd2, 8'hFF); wr(3'd3, 8'd3);
    repeat (100) @(negedge clk);
    countLevel(1'b0, 40, n); check(n == 0, "R8 oversize duty stays high", n, 0);

    // output gate
    wr(3'd2, 8'd5); wr(3'd3, 8'd0);
    wr(3'd0, 8'h14);
    countLevel(1'b1, 80, n); check(n == 0, "R10 gated output low", n, 0);
    wr(3'd0, 8'h94);
    highTime(n); check(n == 20, "R10 output back after gate", n, 20);

    // postscaler k = 0 and flag clear
    wr(3'd0, 8'h84);
    waitRise();
    wr(3'd4, 8'd0);
    check(matchFlag == 0, "R4 flag cleared", matchFlag, 0);
    repeat (40) @(negedge clk);
    check(matchFlag == 1, "R4 flag set on next match k=0", matchFlag, 1);
    wr(3'd0, 8'h9C);            // k = 3
    wr(3'd4, 8'd0);
    repeat (400) @(negedge clk);

    // period lowered below the count
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (countOut == 8'd7) seen = 1;
    end
    wr(3'd1, 8'd3);
    seen = 0;
    for (int i = 0; i < 1500 && !seen; i++) begin
      @(negedge clk);
      if (countOut == 8'd255) seen = 1;
    end
    check(seen, "R11 count runs to 255", seen, 1);
    repeat (200) @(negedge clk);

    checking = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule